// File: doc/BRIEF.md
# CAN Transmit Fault Confinement and Error Interrupt Unit

This block keeps the transmit error count of a CAN node and derives the node's fault-confinement standing from it. The standing is one of three: error active, error passive or bus-off. Single-cycle event pulses arrive from the protocol engine. They report a transmit error, a successful transmission, a freshly detected error code, or the completion of the bus-off recovery sequence. The block presents an 8-bit view of the count and three status flags: warning, passive and bus-off.

A byte-wide enable register lets each status source raise a sticky pending-error flag when that source's own enable bit is set. A master enable bit then decides whether the pending flag reaches the interrupt line. The pending flag is cleared by a write-one-to-clear pulse. All inputs are plain control pins sampled on the rising clock edge. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `can_fault_conf`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the count, every status flag, the pending flag and the enable register, so that `tec_o`, `en_rdata`, `pend_o` and `irq_o` all read 0.
- R2: Outside bus-off, a `tx_err` pulse adds 8 to the count. When `tx_err` and `tx_ok` arrive in the same cycle, only the error is applied.
- R3: Outside bus-off, a `tx_ok` pulse without `tx_err` subtracts 1 from the count. A count of 0 stays at 0.
- R4: `warn_o` is 1 exactly when the count is 96 or more.
- R5: `passive_o` is 1 exactly when the count exceeds 127. It stays set during bus-off.
- R6: A count above 255 puts the node in bus-off. In that state `busoff_o` is 1, `tec_o` reads 255 (saturated), and `tx_err` and `tx_ok` pulses have no effect.
- R7: A `recov_done` pulse during bus-off returns the node to error active with the count at 0 and all three status flags clear. Outside bus-off the pulse has no effect.
- R8: A write (`en_wr`) loads `en_wdata` into the enable register, which reads back on `en_rdata`. Only bits 7 (master), 4 (error code), 2 (bus-off), 1 (passive) and 0 (warning) are stored. Bits 6, 5 and 3 always read 0.
- R9: `pend_o` becomes 1 at the same clock edge as one of these events, provided the matching enable is set: an `err_det` pulse (bit 4), or a 0-to-1 change of `busoff_o` (bit 2), `passive_o` (bit 1) or `warn_o` (bit 0). The enable value in force before that edge applies. An event whose enable is 0 leaves `pend_o` unchanged.
- R10: `pend_o` stays 1 until a `pend_clr` pulse. A new set event in the same cycle as `pend_clr` wins, and the flag stays 1.
- R11: `irq_o` is 1 exactly when `pend_o` is 1 and enable bit 7 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| tx_err | input | 1 | Transmit error event pulse |
| tx_ok | input | 1 | Successful transmission event pulse |
| err_det | input | 1 | New error code latched, event pulse |
| recov_done | input | 1 | Bus-off recovery complete pulse |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 8 | Enable register write value |
| pend_clr | input | 1 | Write-one-to-clear pulse for the pending flag |
| en_rdata | output | 8 | Enable register contents |
| tec_o | output | 8 | Transmit error count, saturated at 255 |
| warn_o | output | 1 | Warning flag |
| passive_o | output | 1 | Error passive flag |
| busoff_o | output | 1 | Bus-off flag |
| pend_o | output | 1 | Sticky pending-error flag |
| irq_o | output | 1 | Error interrupt |

## Verification
Every result is due at the first rising edge that samples the stimulus. The count, the status flags and the enable read-back update at that edge. A flag rise is detected from the next-state count, so the pending flag is also set at that edge. The interrupt follows combinationally from registered state. The bench drives each pulse on a falling edge and compares all seven outputs against its arithmetic model on the next falling edge. No result is therefore sampled at the edge that produces it. The bench sweeps the count through every step up to bus-off and back down to zero, under several enable patterns, and then runs a long pseudo-random event mix.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;

  // enable register bit positions (software-visible layout)
  localparam int unsigned EN_MASTER_BIT = 7;
  localparam int unsigned EN_LEC_BIT    = 4;
  localparam int unsigned EN_BOFF_BIT   = 2;
  localparam int unsigned EN_PASV_BIT   = 1;
  localparam int unsigned EN_WARN_BIT   = 0;
  localparam logic [7:0]  EN_KEEP_MASK  = 8'h97;

  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'd0,
    FC_PASSIVE = 2'd1,
    FC_BUSOFF  = 2'd2
  } fc_state_e;

  // bit order matches enable bits 2..0
  typedef struct packed {
    logic busoff;
    logic passive;
    logic warn;
  } fc_flags_t;

endpackage

// File: rtl/fc_tec_counter.sv
module fc_tec_counter #(
  parameter int unsigned CNT_W      = 9,
  parameter int unsigned ERR_STEP   = 8,
  parameter int unsigned BUSOFF_LIM = 255
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_err,
  input  logic             tx_ok,
  input  logic             recov_done,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_d
);

  localparam logic [CNT_W-1:0] STEP_C = CNT_W'(ERR_STEP);
  localparam logic [CNT_W-1:0] BOFF_C = CNT_W'(BUSOFF_LIM);
  localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

  logic in_busoff;

  assign in_busoff = (cnt_q > BOFF_C);

  always_comb begin
    cnt_d = cnt_q;
    if (in_busoff) begin
      if (recov_done) cnt_d = '0;
    end else if (tx_err) begin
      cnt_d = cnt_q + STEP_C;
    end else if (tx_ok && (cnt_q != '0)) begin
      cnt_d = cnt_q - ONE_C;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

endmodule

// File: rtl/fc_status.sv
module fc_status
  import can_fc_pkg::*;
#(
  parameter int unsigned CNT_W       = 9,
  parameter int unsigned VIS_W       = 8,
  parameter int unsigned WARN_LIM    = 96,
  parameter int unsigned PASSIVE_LIM = 127,
  parameter int unsigned BUSOFF_LIM  = 255
) (
  input  logic [CNT_W-1:0] cnt_q,
  input  logic [CNT_W-1:0] cnt_d,
  output fc_flags_t        flags_q,
  output fc_flags_t        flags_rise,
  output logic [VIS_W-1:0] tec_vis
);

  localparam logic [CNT_W-1:0] WARN_C = CNT_W'(WARN_LIM);
  localparam logic [CNT_W-1:0] PASV_C = CNT_W'(PASSIVE_LIM);
  localparam logic [CNT_W-1:0] BOFF_C = CNT_W'(BUSOFF_LIM);

  function automatic fc_flags_t flags_of(input logic [CNT_W-1:0] c);
    fc_state_e st;
    fc_flags_t f;
    if (c > BOFF_C)      st = FC_BUSOFF;
    else if (c > PASV_C) st = FC_PASSIVE;
    else                 st = FC_ACTIVE;
    f.busoff  = (st == FC_BUSOFF);
    f.passive = (st != FC_ACTIVE);
    f.warn    = (c >= WARN_C);
    return f;
  endfunction

  fc_flags_t flags_n;

  assign flags_q    = flags_of(cnt_q);
  assign flags_n    = flags_of(cnt_d);
  assign flags_rise = flags_n & ~flags_q;

  generate
    if (CNT_W > VIS_W) begin : g_sat
      localparam logic [CNT_W-1:0] VMAX_C = CNT_W'({VIS_W{1'b1}});
      assign tec_vis = (cnt_q > VMAX_C) ? {VIS_W{1'b1}} : cnt_q[VIS_W-1:0];
    end else begin : g_ext
      assign tec_vis = VIS_W'(cnt_q);
    end
  endgenerate

endmodule

// File: rtl/fc_irq_ctrl.sv
module fc_irq_ctrl
  import can_fc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en_wr,
  input  logic [7:0] en_wdata,
  input  logic       err_det,
  input  logic       pend_clr,
  input  fc_flags_t  flags_rise,
  output logic [7:0] en_q,
  output logic       pend_q,
  output logic       irq
);

  logic      pend_set;
  fc_flags_t src_en;

  assign src_en = '{busoff:  en_q[EN_BOFF_BIT],
                    passive: en_q[EN_PASV_BIT],
                    warn:    en_q[EN_WARN_BIT]};

  assign pend_set = (err_det && en_q[EN_LEC_BIT]) || (|(flags_rise & src_en));

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 8'h00;
      pend_q <= 1'b0;
    end else begin
      if (en_wr) en_q <= en_wdata & EN_KEEP_MASK;
      if (pend_set)      pend_q <= 1'b1;
      else if (pend_clr) pend_q <= 1'b0;
    end
  end

  assign irq = pend_q && en_q[EN_MASTER_BIT];

endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf
  import can_fc_pkg::*;
#(
  parameter int unsigned CNT_W       = 9,
  parameter int unsigned VIS_W       = 8,
  parameter int unsigned ERR_STEP    = 8,
  parameter int unsigned WARN_LIM    = 96,
  parameter int unsigned PASSIVE_LIM = 127,
  parameter int unsigned BUSOFF_LIM  = 255
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tx_err,
  input  logic       tx_ok,
  input  logic       err_det,
  input  logic       recov_done,
  input  logic       en_wr,
  input  logic [7:0] en_wdata,
  input  logic       pend_clr,
  output logic [7:0] en_rdata,
  output logic [VIS_W-1:0] tec_o,
  output logic       warn_o,
  output logic       passive_o,
  output logic       busoff_o,
  output logic       pend_o,
  output logic       irq_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  fc_flags_t        flags_q;
  fc_flags_t        flags_rise;

  fc_tec_counter #(
    .CNT_W     (CNT_W),
    .ERR_STEP  (ERR_STEP),
    .BUSOFF_LIM(BUSOFF_LIM)
  ) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .tx_err    (tx_err),
    .tx_ok     (tx_ok),
    .recov_done(recov_done),
    .cnt_q     (cnt_q),
    .cnt_d     (cnt_d)
  );

  fc_status #(
    .CNT_W      (CNT_W),
    .VIS_W      (VIS_W),
    .WARN_LIM   (WARN_LIM),
    .PASSIVE_LIM(PASSIVE_LIM),
    .BUSOFF_LIM (BUSOFF_LIM)
  ) u_stat (
    .cnt_q     (cnt_q),
    .cnt_d     (cnt_d),
    .flags_q   (flags_q),
    .flags_rise(flags_rise),
    .tec_vis   (tec_o)
  );

  fc_irq_ctrl u_irq (
    .clk       (clk),
    .rst       (rst),
    .en_wr     (en_wr),
    .en_wdata  (en_wdata),
    .err_det   (err_det),
    .pend_clr  (pend_clr),
    .flags_rise(flags_rise),
    .en_q      (en_rdata),
    .pend_q    (pend_o),
    .irq       (irq_o)
  );

  assign warn_o    = flags_q.warn;
  assign passive_o = flags_q.passive;
  assign busoff_o  = flags_q.busoff;

endmodule

// File: rtl/can_fault_conf_chk.sv
module can_fault_conf_chk (
  input logic       clk,
  input logic       rst,
  input logic       tx_err,
  input logic       tx_ok,
  input logic       err_det,
  input logic       recov_done,
  input logic       en_wr,
  input logic [7:0] en_wdata,
  input logic       pend_clr,
  input logic [7:0] en_rdata,
  input logic [7:0] tec_o,
  input logic       warn_o,
  input logic       passive_o,
  input logic       busoff_o,
  input logic       pend_o,
  input logic       irq_o
);

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (tec_o == 8'd0) && (en_rdata == 8'd0) && !pend_o); // R1
  AST_ERR_STEP: assert property (@(posedge clk) disable iff (rst)
    (tx_err && !busoff_o && (tec_o <= 8'd247)) |=> (tec_o == $past(tec_o) + 8'd8)); // R2
  AST_OK_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (tx_ok && !tx_err && (tec_o == 8'd0)) |=> (tec_o == 8'd0)); // R3
  AST_WARN_LEVEL: assert property (@(posedge clk) disable iff (rst) !warn_o |-> (tec_o < 8'd96)); // R4
  AST_BUSOFF_NESTS: assert property (@(posedge clk) disable iff (rst) busoff_o |-> (passive_o && warn_o)); // R5
  AST_BUSOFF_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (tx_err && !busoff_o && (tec_o >= 8'd248)) |=> busoff_o); // R6
  AST_BUSOFF_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busoff_o && !recov_done) |=> (busoff_o && (tec_o == 8'hFF))); // R6
  AST_RECOVER: assert property (@(posedge clk) disable iff (rst)
    (busoff_o && recov_done) |=> ((tec_o == 8'd0) && !warn_o && !passive_o && !busoff_o)); // R7
  AST_RECOV_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!busoff_o && recov_done && !tx_err && !tx_ok) |=> $stable(tec_o)); // R7
  AST_EN_WRITE: assert property (@(posedge clk) disable iff (rst)
    en_wr |=> (en_rdata == ($past(en_wdata) & 8'h97))); // R8
  AST_EN_RESERVED: assert property (@(posedge clk) disable iff (rst) ((en_rdata & 8'h68) == 8'h00)); // R8
  AST_DET_SETS: assert property (@(posedge clk) disable iff (rst) (err_det && en_rdata[4]) |=> pend_o); // R9
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst) (pend_o && !pend_clr) |=> pend_o); // R10
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst) irq_o |-> (pend_o && en_rdata[7])); // R11

endmodule

bind can_fault_conf can_fault_conf_chk u_chk (.*);

// File: tb/tb_can_fault_conf.sv
module tb_can_fault_conf;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_err = 1'b0, tx_ok = 1'b0, err_det = 1'b0, recov_done = 1'b0;
  logic       en_wr = 1'b0, pend_clr = 1'b0;
  logic [7:0] en_wdata = 8'h00;
  logic [7:0] en_rdata, tec_o;
  logic       warn_o, passive_o, busoff_o, pend_o, irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // model state
  int         m_cnt  = 0;
  logic [7:0] m_en   = 8'h00;
  bit         m_pend = 1'b0;

  always #2.5 clk = ~clk;

  can_fault_conf dut (
    .clk(clk), .rst(rst), .tx_err(tx_err), .tx_ok(tx_ok), .err_det(err_det),
    .recov_done(recov_done), .en_wr(en_wr), .en_wdata(en_wdata), .pend_clr(pend_clr),
    .en_rdata(en_rdata), .tec_o(tec_o), .warn_o(warn_o), .passive_o(passive_o),
    .busoff_o(busoff_o), .pend_o(pend_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  // one cycle: drive at falling edge, model the edge, compare at next falling edge
  task automatic step(input string tag, input bit r, input bit e, input bit o, input bit d,
                      input bit rc, input bit c, input bit w, input logic [7:0] wd);
    int nc;
    bit ow, op, ob, nw, np, nb, set;
    rst = r; tx_err = e; tx_ok = o; err_det = d; recov_done = rc;
    pend_clr = c; en_wr = w; en_wdata = wd;
    ow = (m_cnt >= 96); op = (m_cnt > 127); ob = (m_cnt > 255);
    if (r) begin
      m_cnt = 0; m_en = 8'h00; m_pend = 1'b0;
    end else begin
      nc = m_cnt;
      if (ob) begin
        if (rc) nc = 0;
      end else if (e) nc = m_cnt + 8;
      else if (o && m_cnt > 0) nc = m_cnt - 1;
      nw = (nc >= 96); np = (nc > 127); nb = (nc > 255);
      set = (d && m_en[4]) || (nb && !ob && m_en[2]) || (np && !op && m_en[1]) ||
            (nw && !ow && m_en[0]);
      if (set) m_pend = 1'b1;
      else if (c) m_pend = 1'b0;
      if (w) m_en = wd & 8'h97;
      m_cnt = nc;
    end
    @(negedge clk);
    chk(tag, "tec", int'(tec_o), (m_cnt > 255) ? 255 : m_cnt);
    chk(tag, "warn", int'(warn_o), int'(m_cnt >= 96));
    chk(tag, "passive", int'(passive_o), int'(m_cnt > 127));
    chk(tag, "busoff", int'(busoff_o), int'(m_cnt > 255));
    chk(tag, "pend", int'(pend_o), int'(m_pend));
    chk(tag, "irq", int'(irq_o), int'(m_pend && m_en[7]));
    chk(tag, "en", int'(en_rdata), int'(m_en));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    @(negedge clk);
    // R1: reset state
    step("R1", 1, 0, 0, 0, 0, 0, 0, 8'h00);
    step("R1", 1, 1, 1, 1, 1, 0, 1, 8'hFF);
    // R8: reserved bits dropped
    step("R8", 0, 0, 0, 0, 0, 0, 1, 8'hFF);
    step("R8", 0, 0, 0, 0, 0, 0, 1, 8'h68);
    step("R8", 0, 0, 0, 0, 0, 0, 1, 8'h97);
    // R2/R4/R5/R6: climb to bus-off with periodic pend clears
    for (int i = 0; i < 34; i++) step("R2", 0, 1, 0, 0, 0, (i % 5) == 4, 0, 8'h00);
    // R6: events ignored in bus-off
    for (int i = 0; i < 6; i++) step("R6", 0, i[0], !i[0], 0, 0, 0, 0, 8'h00);
    // R10: clear
    step("R10", 0, 0, 0, 0, 0, 1, 0, 8'h00);
    // R7: recovery
    step("R7", 0, 0, 0, 0, 1, 0, 0, 8'h00);
    // R7: recovery outside bus-off ignored
    step("R7", 0, 1, 0, 0, 0, 0, 0, 8'h00);
    step("R7", 0, 0, 0, 0, 1, 0, 0, 8'h00);
    // R4: up to 104, then R3 walk down past zero
    for (int i = 0; i < 12; i++) step("R4", 0, 1, 0, 0, 0, 0, 0, 8'h00);
    for (int i = 0; i < 110; i++) step("R3", 0, 0, 1, 0, 0, 0, 0, 8'h00);
    // R2: simultaneous error and success
    for (int i = 0; i < 3; i++) step("R2", 0, 1, 1, 0, 0, 0, 0, 8'h00);
    // R10: set and clear in the same cycle
    step("R10", 0, 0, 0, 0, 0, 1, 0, 8'h00);
    step("R10", 0, 0, 0, 1, 0, 1, 0, 8'h00);
    // R11: master off keeps irq low
    step("R11", 0, 0, 0, 0, 0, 0, 1, 8'h17);
    step("R11", 0, 0, 0, 1, 0, 0, 0, 8'h00);
    step("R11", 0, 0, 0, 0, 0, 0, 1, 8'h80);
    // R9: all source enables off, nothing sets pend
    step("R9", 0, 0, 0, 0, 0, 1, 1, 8'h80);
    for (int i = 0; i < 40; i++) step("R9", 0, 1, 0, 1, 0, 0, 0, 8'h00);
    step("R9", 0, 0, 0, 0, 1, 0, 0, 8'h00);
    // R9: each source enable alone
    step("R9", 0, 0, 0, 0, 0, 0, 1, 8'h81);
    for (int i = 0; i < 13; i++) step("R9", 0, 1, 0, 0, 0, 0, 0, 8'h00);
    step("R9", 0, 0, 0, 0, 0, 1, 1, 8'h82);
    for (int i = 0; i < 4; i++) step("R9", 0, 1, 0, 0, 0, 0, 0, 8'h00);
    step("R9", 0, 0, 0, 0, 0, 1, 1, 8'h84);
    for (int i = 0; i < 17; i++) step("R9", 0, 1, 0, 0, 0, 0, 0, 8'h00);
    // R1: reset in mid-run
    step("R1", 1, 0, 0, 0, 0, 0, 0, 8'h00);
    step("R1", 0, 0, 0, 0, 0, 0, 0, 8'h00);
    // mixed pseudo-random events
    lf = 16'hACE1;
    step("R9", 0, 0, 0, 0, 0, 0, 1, 8'hFF);
    for (int i = 0; i < 4000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step("R2", 0, lf[3:0] < 4'd3, lf[7:4] < 4'd9, lf[10:8] == 3'd0,
           lf[15:12] < 4'd2, lf[13:11] == 3'd7, lf[15:8] == 8'h5A, lf[7:0]);
    end
    done = 1'b1;
    summary();
    $finish;
  end

endmodule